// File: doc/BRIEF.md
# Turn-off Broadcast and Acknowledge Collector

This block runs the power-down handshake for one node of a tree that has several downstream ports. A turn-off request can come from the upstream side or from a local power manager. When it is accepted, the block captures which downstream ports are active at that moment. It then issues one turn-off message to each of those ports. A port's message waits until that port has no earlier packets still queued, so the message never overtakes traffic that was posted before it.

The block then collects one acknowledge from every captured port. When the last one arrives, it raises a level that says power may now be changed. If the request came from upstream, it also sends a single acknowledge pulse back upstream. An optional watchdog ends a wait that has run too long and raises a timeout flag instead. An abort input returns the block to idle from any state.

Top module: `turnoff_collector`

## Requirements
- R1: After reset, `tof_msg`, `busy_o`, `ack_up`, `clear_pd` and `timed_out` are all low.
- R2: A request is accepted when the block is not waiting and `abort` is low. On the accepting edge, `port_active` is captured as the expected set. Each port in that set gets exactly one single-cycle `tof_msg` pulse, and no other port gets one. `busy_o` is high while the block waits.
- R3: Ordering: no `tof_msg` bit is high while the same port's `port_busy` bit is high. A held message is issued combinationally in the first waiting cycle in which that port's `port_busy` is low.
- R4: Once every expected port has acknowledged, `clear_pd` goes high after the edge that sampled the last acknowledge and stays high. For an upstream-originated sequence (`req_up`, which takes priority over `req_local`), `ack_up` pulses for exactly that one cycle. For a local sequence, `ack_up` stays low.
- R5: An acknowledge does not count toward completion in any of these cases: it comes from a port outside the expected set, it repeats an acknowledge already counted, or it arrives before that port's message was issued.
- R6: If the captured set is empty, `clear_pd` is high in the cycle after the accepting edge. `ack_up` pulses in that cycle if the request came from upstream.
- R7: With `tmo_en` high, if the wait has not completed, `timed_out` rises after the (`tmo_limit`+1)-th edge following the accepting edge. After a timeout, `ack_up` and `clear_pd` stay low, even if late acknowledges arrive.
- R8: A request that arrives while `busy_o` is high is refused. It reloads no set, issues no message, and does not change the origin of the sequence in progress.
- R9: `abort` takes the block to idle on the next edge, with all outputs low, and clears the expected set. Acknowledges that arrive afterwards cause no completion.
- R10: Changes of `port_active` after the accepting edge have no effect on the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_up | input | 1 | Turn-off request from upstream |
| req_local | input | 1 | Turn-off request from local power manager |
| abort | input | 1 | Return to idle, clear expected set |
| port_active | input | PORTS | Ports currently active |
| port_busy | input | PORTS | Port still has earlier packets queued |
| port_ack | input | PORTS | Acknowledge received from port |
| tof_msg | output | PORTS | Turn-off message issued to port (one-cycle pulse) |
| tmo_en | input | 1 | Enable the wait timeout |
| tmo_limit | input | TMO_W | Timeout limit in cycles |
| busy_o | output | 1 | Sequence waiting for messages/acknowledges |
| ack_up | output | 1 | Single acknowledge pulse upstream |
| clear_pd | output | 1 | Cleared to change power state |
| timed_out | output | 1 | Wait ended by timeout |

## Verification
The main check is a sweep over all sixteen active-port sets of a four-port build, run once with an upstream request and once with a local one. This separates the empty-set shortcut, the per-port message fan-out, and whether `ack_up` is present or absent. Within each run, acknowledges from ports outside the set, a repeated acknowledge, and in-order acknowledges show that only the last genuine acknowledge completes the wait. Separate patterns hold one port busy and send it an acknowledge early, to test ordering. Others raise a second request and change the active set mid-wait, expire the timeout at a small limit, and abort mid-wait followed by acknowledges.

// File: rtl/tofc_pkg.sv
package tofc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2,
    ST_TMO  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/tofc_lane.sv
// Per-port tracking: message still to send, acknowledge still owed.
module tofc_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic active,
  input  logic en,
  input  logic clr,
  input  logic busy,
  input  logic ack,
  output logic msg,
  output logic keep
);
  logic snd_q, snd_d, pnd_q, pnd_d, hit, upd;

  // message leaves only when no earlier packet is queued on this port
  assign msg  = en & snd_q & ~busy;
  // acknowledge counts only if owed and the message already went out
  assign hit  = en & ack & pnd_q & ~snd_q;
  assign keep = pnd_q & ~hit;
  assign upd  = clr | load | en;

  always_comb begin
    snd_d = snd_q;
    pnd_d = pnd_q;
    if (clr) begin
      snd_d = 1'b0;
      pnd_d = 1'b0;
    end else if (load) begin
      snd_d = active;
      pnd_d = active;
    end else begin
      if (msg) snd_d = 1'b0;
      pnd_d = keep;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snd_q <= 1'b0;
      pnd_q <= 1'b0;
    end else if (upd) begin
      snd_q <= snd_d;
      pnd_q <= pnd_d;
    end
  end
endmodule

// File: rtl/tofc_timer.sv
// Wait-length counter; expires when the count equals the limit.
module tofc_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             enable,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             upd;

  assign expire = run & enable & (cnt_q == limit);
  assign upd    = start | run;

  always_comb begin
    if (start) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/turnoff_collector.sv
module turnoff_collector
  import tofc_pkg::*;
#(
  parameter int PORTS = 4,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_up,
  input  logic             req_local,
  input  logic             abort,
  input  logic [PORTS-1:0] port_active,
  input  logic [PORTS-1:0] port_busy,
  input  logic [PORTS-1:0] port_ack,
  output logic [PORTS-1:0] tof_msg,
  input  logic             tmo_en,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             busy_o,
  output logic             ack_up,
  output logic             clear_pd,
  output logic             timed_out
);
  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_s = rst_sync_q[SYNC_STAGES-1];

  seq_state_t       state_q, state_d;
  logic             from_up_q, from_up_d;
  logic             ack_up_q, ack_up_d;
  logic             waiting, accept, any_active, all_done, expire, lane_clr;
  logic [PORTS-1:0] keep_v;

  assign waiting    = (state_q == ST_WAIT);
  assign any_active = |port_active;
  assign accept     = (req_up | req_local) & ~waiting & ~abort;
  assign all_done   = ~|keep_v;
  assign lane_clr   = abort | (waiting & expire & ~all_done);

  for (genvar g = 0; g < PORTS; g++) begin : g_lane
    tofc_lane u_lane (
      .clk   (clk),
      .rst_n (rst_s),
      .load  (accept),
      .active(port_active[g]),
      .en    (waiting),
      .clr   (lane_clr),
      .busy  (port_busy[g]),
      .ack   (port_ack[g]),
      .msg   (tof_msg[g]),
      .keep  (keep_v[g])
    );
  end

  tofc_timer #(.TMO_W(TMO_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_s),
    .start (accept),
    .run   (waiting),
    .enable(tmo_en),
    .limit (tmo_limit),
    .expire(expire)
  );

  // next state
  always_comb begin
    state_d   = state_q;
    from_up_d = from_up_q;
    ack_up_d  = 1'b0;
    if (abort) begin
      state_d = ST_IDLE;
    end else if (accept) begin
      from_up_d = req_up;
      if (any_active) begin
        state_d = ST_WAIT;
      end else begin
        state_d  = ST_DONE;
        ack_up_d = req_up;
      end
    end else if (waiting) begin
      if (all_done) begin
        state_d  = ST_DONE;
        ack_up_d = from_up_q;
      end else if (expire) begin
        state_d = ST_TMO;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q   <= ST_IDLE;
      from_up_q <= 1'b0;
      ack_up_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      ack_up_q <= ack_up_d;
      if (accept) from_up_q <= from_up_d;
    end
  end

  assign busy_o    = waiting;
  assign ack_up    = ack_up_q;
  assign clear_pd  = (state_q == ST_DONE);
  assign timed_out = (state_q == ST_TMO);
endmodule

// File: rtl/tofc_chk.sv
module tofc_chk #(
  parameter int PORTS = 4,
  parameter int TMO_W = 16
) (
  input logic             clk,
  input logic             rst_s,
  input logic             req_up,
  input logic             req_local,
  input logic             abort,
  input logic [PORTS-1:0] port_active,
  input logic [PORTS-1:0] port_busy,
  input logic [PORTS-1:0] tof_msg,
  input logic             busy_o,
  input logic             ack_up,
  input logic             clear_pd,
  input logic             timed_out
);
  // R2: messages only go out while a sequence waits
  assert_msg_in_wait_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (tof_msg != '0) |-> busy_o);

  // R3: no message to a port that still has queued packets
  assert_msg_ordered_R3: assert property (@(posedge clk) disable iff (!rst_s)
    ((tof_msg & port_busy) == '0));

  // R4: status outputs are mutually exclusive
  assert_status_excl_R4: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({busy_o, clear_pd, timed_out}));

  // R4: the upstream acknowledge only accompanies completion, and is one cycle
  assert_ack_with_done_R4: assert property (@(posedge clk) disable iff (!rst_s)
    ack_up |-> clear_pd);
  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_s)
    ack_up |=> !ack_up);

  // R6: empty captured set completes one cycle later
  assert_empty_done_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (!busy_o && (req_up || req_local) && !abort && port_active == '0) |=> clear_pd);

  // R7: a timed-out sequence never acknowledges
  assert_tmo_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_s)
    timed_out |-> !ack_up && !clear_pd);

  // R9: abort returns to idle
  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_s)
    abort |=> (!busy_o && !clear_pd && !timed_out && !ack_up));
endmodule

bind turnoff_collector tofc_chk #(.PORTS(PORTS), .TMO_W(TMO_W)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .req_up     (req_up),
  .req_local  (req_local),
  .abort      (abort),
  .port_active(port_active),
  .port_busy  (port_busy),
  .tof_msg    (tof_msg),
  .busy_o     (busy_o),
  .ack_up     (ack_up),
  .clear_pd   (clear_pd),
  .timed_out  (timed_out)
);

// File: tb/turnoff_collector_test.sv
`timescale 1ns/1ps
module turnoff_collector_test;
  localparam int P  = 4;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_up, req_local, abort, tmo_en;
  logic [P-1:0]  port_active, port_busy, port_ack, tof_msg;
  logic [TW-1:0] tmo_limit;
  logic          busy_o, ack_up, clear_pd, timed_out;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  turnoff_collector #(.PORTS(P), .TMO_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .req_up(req_up), .req_local(req_local),
    .abort(abort), .port_active(port_active), .port_busy(port_busy),
    .port_ack(port_ack), .tof_msg(tof_msg), .tmo_en(tmo_en),
    .tmo_limit(tmo_limit), .busy_o(busy_o), .ack_up(ack_up),
    .clear_pd(clear_pd), .timed_out(timed_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic do_abort();
    abort = 1'b1;
    step();
    abort = 1'b0;
    #1;
    chk(!busy_o && !clear_pd && !timed_out && !ack_up, "R9 abort idle",
        {busy_o, clear_pd, timed_out, ack_up}, 0);
  endtask

  task automatic run_seq(input logic [P-1:0] mask, input bit up);
    int remaining;
    bit first;
    remaining = $countones(mask);
    first = 1'b1;
    port_active = mask;
    req_up = up;
    req_local = ~up;
    step();
    req_up = 1'b0;
    req_local = 1'b0;
    port_active = ~mask;  // R10: later changes must not matter
    #1;
    if (mask == '0) begin
      chk(clear_pd && !busy_o, "R6 empty done", clear_pd, 1);
      chk(ack_up == up, "R6 empty ack_up", ack_up, up);
    end else begin
      chk(busy_o, "R2 busy", busy_o, 1);
      chk(tof_msg == mask, "R2 fan-out", tof_msg, mask);
      step();
      chk(tof_msg == '0, "R2 single message", tof_msg, 0);
      port_ack = ~mask;
      step();
      port_ack = '0;
      #1;
      chk(busy_o && !clear_pd, "R5 foreign ack ignored", clear_pd, 0);
      for (int i = 0; i < P; i++) begin
        if (mask[i]) begin
          port_ack = P'(1) << i;
          step();
          port_ack = '0;
          remaining--;
          #1;
          if (remaining > 0) begin
            chk(busy_o && !clear_pd && !ack_up, "R4 not yet done", clear_pd, 0);
            if (first) begin
              port_ack = P'(1) << i;
              step();
              port_ack = '0;
              #1;
              chk(busy_o && !clear_pd, "R5 repeated ack ignored", clear_pd, 0);
            end
          end else begin
            chk(clear_pd && !busy_o, "R4 done", clear_pd, 1);
            chk(ack_up == up, "R4 ack_up origin", ack_up, up);
          end
          first = 1'b0;
        end
      end
    end
    step();
    chk(!ack_up && clear_pd, "R4 single ack pulse", ack_up, 0);
    do_abort();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_up = 1'b0; req_local = 1'b0; abort = 1'b0; tmo_en = 1'b0;
    port_active = '0; port_busy = '0; port_ack = '0; tmo_limit = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();
    chk(!busy_o && !ack_up && !clear_pd && !timed_out && tof_msg == '0,
        "R1 reset state", {busy_o, ack_up, clear_pd, timed_out}, 0);

    // sweep every active set, both origins
    for (int m = 0; m < (1 << P); m++) begin
      run_seq(P'(m), 1'b1);
      run_seq(P'(m), 1'b0);
    end

    // R3: ordering behind queued packets, early ack ignored
    port_active = 4'b0011; port_busy = 4'b0001; req_up = 1'b1;
    step();
    req_up = 1'b0; #1;
    chk(tof_msg == 4'b0010, "R3 held message", tof_msg, 2);
    step();
    chk(tof_msg == 4'b0000, "R3 still held", tof_msg, 0);
    port_ack = 4'b0001; step();           // before its message: R5
    port_ack = 4'b0010; step();
    port_ack = '0; #1;
    chk(busy_o && !clear_pd, "R5 early ack ignored", clear_pd, 0);
    port_busy = '0; #1;
    chk(tof_msg == 4'b0001, "R3 released message", tof_msg, 1);
    step();
    port_ack = 4'b0001; step();
    port_ack = '0; #1;
    chk(clear_pd && ack_up, "R3 completion after ordered send", clear_pd, 1);
    do_abort();

    // R8: second request refused mid-wait; R10 active change ignored
    port_active = 4'b0011; req_up = 1'b1;
    step();
    req_up = 1'b0; step();
    port_active = 4'b1111; req_local = 1'b1; #1;
    chk(tof_msg == '0, "R8 no new message", tof_msg, 0);
    step();
    req_local = 1'b0; #1;
    chk(tof_msg == '0 && busy_o, "R8 refused", tof_msg, 0);
    port_ack = 4'b0011; step();
    port_ack = '0; #1;
    chk(clear_pd, "R8 original set kept", clear_pd, 1);
    chk(ack_up, "R8 origin kept", ack_up, 1);
    do_abort();

    // R7: timeout at limit 5
    tmo_en = 1'b1; tmo_limit = 8'd5;
    port_active = 4'b0001; req_up = 1'b1;
    step();
    req_up = 1'b0;
    step();
    repeat (4) step();
    chk(!timed_out && busy_o, "R7 not yet timed out", timed_out, 0);
    step();
    chk(timed_out && !clear_pd && !ack_up, "R7 timed out", timed_out, 1);
    port_ack = 4'b0001; step();
    port_ack = '0; #1;
    chk(timed_out && !ack_up && !clear_pd, "R7 late ack ignored", ack_up, 0);
    do_abort();

    // R7: limit 0 expires after one waiting cycle
    tmo_limit = 8'd0;
    port_active = 4'b0100; req_local = 1'b1;
    step();
    req_local = 1'b0; #1;
    chk(!timed_out, "R7 limit 0 first cycle", timed_out, 0);
    step();
    chk(timed_out, "R7 limit 0 expiry", timed_out, 1);
    do_abort();
    tmo_en = 1'b0;

    // R9: abort mid-wait, then acks cause nothing
    port_active = 4'b1111; req_up = 1'b1;
    step();
    req_up = 1'b0;
    do_abort();
    port_ack = 4'b1111; step();
    port_ack = '0; step();
    chk(!clear_pd && !ack_up && !busy_o, "R9 mask cleared", clear_pd, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule